// File: doc/BRIEF.md
# Dual-Lane Paged Reed-Solomon Encoder

This block adds Reed-Solomon parity to NAND page data as it streams toward the flash bus. Every clock it accepts one bus word that carries one byte per lane. Each lane runs its own systematic encoder over GF(2^8). The default build uses two lanes, 243 message bytes per block and 12 parity bytes, so that six symbol errors per 255-byte codeword can be corrected. Byte 2k of the page travels in lane 0 and byte 2k+1 in lane 1, so each lane encodes a contiguous stream of its own bytes.

Message words pass straight through to the output. When a lane has taken a full block of message symbols, the block sends out that block's parity words. If the page ends partway through a block, the block fills the rest of the block with zero words. These padding words count toward the parity, but they are marked so that the downstream side does not write them. Both edges use a valid/ready handshake, and the input-to-output path has no register in it. A stalled output therefore freezes the whole stream.

Top module: `rs_page_encoder`

## Requirements
- R1: After reset, or after a reset that arrives in the middle of a page, the block is at the start of a message block with cleared parity state. With `inValid` low, `outValid` is low and `inReady` follows `outReady`.
- R2: In the message phase, `outValid` equals `inValid`, `inReady` equals `outReady`, and `outData` equals `inData` with `outWrite`=1 and `outParity`=0.
- R3: Each lane counts MSG_LEN accepted symbols per block and then emits NPAR parity bytes. These bytes are the remainder of m(x)·x^NPAR divided by g(x) = ∏(x+α^i) for i = 0..NPAR-1, computed in GF(2^8) with field polynomial 0x11D and α = 0x02. The highest-order coefficient comes first. Lane 0 uses bits 7:0 of the bus word and lane 1 uses bits 15:8.
- R4: Parity words are flagged with `outParity`=1 and `outWrite`=1.
- R5: If `inLast` is accepted on a word that does not end a block, the block emits zero padding words until the block is full. Each padding word has `outValid`=1, `outData`=0 and `outWrite`=0. The padding bytes are included in the parity.
- R6: If `inLast` is accepted on the word that ends a block, parity follows at once with no padding.
- R7: During padding and parity words `inReady` is 0, and input presented in those cycles has no effect on the output.
- R8: While a padding or parity word is offered with `outReady` low, `outData`, `outWrite` and `outParity` hold, and the stream does not advance.
- R9: The parity state clears after each block, so two blocks that carry identical data produce identical parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Block accepts the input word |
| inData | input | LANES*8 | Page word, one byte per lane |
| inLast | input | 1 | Word is the last of the page |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | LANES*8 | Message, padding or parity word |
| outWrite | output | 1 | Word is to be written (0 for padding) |
| outParity | output | 1 | Word carries parity bytes |

## Verification
The bench builds the block with LANES=2 and NPAR=12, and cuts MSG_LEN down to 5. With blocks this short, a page of a few words crosses several block boundaries. This brings exact-fit pages, pages of one word, multi-block pages with identical blocks, and padding runs that are longer than the message part within reach in a few hundred cycles. The full parity width is still checked against an independently computed generator. Output stalls and input gaps are placed during message, padding and parity phases. A reset in the middle of a page shows that no remainder survives into the next page.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  localparam int SYM_W = 8;
  // x^8 + x^4 + x^3 + x^2 + 1
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_ZERO = 2'd1,
    SEL_PAR  = 2'd2
  } outSel_e;

  typedef enum logic [1:0] {
    PH_MSG = 2'd0,
    PH_PAD = 2'd1,
    PH_PAR = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    outSel_e sel;
    logic    feed;
    logic    unload;
  } laneCtl_t;

  function automatic logic [SYM_W-1:0] gfMul(input logic [SYM_W-1:0] a,
                                             input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] acc;
    logic [SYM_W-1:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SYM_W-1] ? ({x[SYM_W-2:0], 1'b0} ^ FIELD_POLY[SYM_W-1:0])
                     : {x[SYM_W-2:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/rs_enc_lane.sv
module rs_enc_lane
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feed,
  input  logic             unload,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] parOut
);

  // generator coefficients x^0..x^(NPAR-1); x^NPAR term is 1
  function automatic logic [NPAR*SYM_W-1:0] genPoly();
    logic [NPAR:0][SYM_W-1:0] c;
    logic [SYM_W-1:0]         root;
    logic [NPAR*SYM_W-1:0]    flat;
    c    = '0;
    c[0] = 8'h01;
    root = 8'h01;
    for (int k = 0; k < NPAR; k++) begin
      for (int j = NPAR; j > 0; j--) c[j] = c[j-1] ^ gfMul(c[j], root);
      c[0] = gfMul(c[0], root);
      root = gfMul(root, 8'h02);
    end
    for (int j = 0; j < NPAR; j++) flat[j*SYM_W +: SYM_W] = c[j];
    return flat;
  endfunction

  localparam logic [NPAR*SYM_W-1:0] GEN = genPoly();

  logic [NPAR-1:0][SYM_W-1:0] rem;
  logic [NPAR-1:0][SYM_W-1:0] remNext;
  logic [NPAR-1:0][SYM_W-1:0] tap;
  logic [SYM_W-1:0]           fb;

  assign fb = sym ^ rem[NPAR-1];

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    assign tap[i] = gfMul(fb, GEN[i*SYM_W +: SYM_W]);
  end

  always_comb begin
    remNext = rem;
    if (feed) begin
      remNext[0] = tap[0];
      for (int i = 1; i < NPAR; i++) remNext[i] = rem[i-1] ^ tap[i];
    end else if (unload) begin
      // shift parity out top-first; zeros fill behind, leaving a cleared register
      remNext[0] = '0;
      for (int i = 1; i < NPAR; i++) remNext[i] = rem[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rem <= '0;
    else     rem <= remNext;
  end

  assign parOut = rem[NPAR-1];

endmodule

// File: rtl/rs_enc_datapath.sv
module rs_enc_datapath
  import rs_enc_pkg::*;
#(
  parameter int LANES = 2,
  parameter int NPAR  = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  laneCtl_t               ctl,
  input  logic [LANES*SYM_W-1:0] inData,
  output logic [LANES*SYM_W-1:0] outData
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SYM_W-1:0] sym;
    logic [SYM_W-1:0] par;
    logic [SYM_W-1:0] laneOut;

    assign sym = (ctl.sel == SEL_ZERO) ? '0 : inData[l*SYM_W +: SYM_W];

    rs_enc_lane #(.NPAR(NPAR)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .feed   (ctl.feed),
      .unload (ctl.unload),
      .sym    (sym),
      .parOut (par)
    );

    always_comb begin
      case (ctl.sel)
        SEL_PAR:  laneOut = par;
        SEL_ZERO: laneOut = '0;
        default:  laneOut = inData[l*SYM_W +: SYM_W];
      endcase
    end

    assign outData[l*SYM_W +: SYM_W] = laneOut;
  end

endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int MSG_LEN = 243,
  parameter int NPAR    = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     inLast,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output logic     outWrite,
  output logic     outParity,
  output laneCtl_t ctl
);

  localparam int CNT_W = $clog2(MSG_LEN + 1);
  localparam int PAR_W = $clog2(NPAR + 1);
  localparam logic [CNT_W-1:0] SYM_LAST = CNT_W'(MSG_LEN - 1);
  localparam logic [PAR_W-1:0] PAR_LAST = PAR_W'(NPAR - 1);

  phase_e           phase;
  logic [CNT_W-1:0] symCnt;
  logic [PAR_W-1:0] parCnt;
  logic             fire;

  assign outValid  = (phase == PH_MSG) ? inValid : 1'b1;
  assign inReady   = (phase == PH_MSG) && outReady;
  assign outWrite  = (phase != PH_PAD);
  assign outParity = (phase == PH_PAR);
  assign fire      = outValid && outReady;

  always_comb begin
    ctl.feed   = fire && (phase != PH_PAR);
    ctl.unload = fire && (phase == PH_PAR);
    case (phase)
      PH_PAD:  ctl.sel = SEL_ZERO;
      PH_PAR:  ctl.sel = SEL_PAR;
      default: ctl.sel = SEL_PASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_MSG;
      symCnt <= '0;
      parCnt <= '0;
    end else if (fire) begin
      case (phase)
        PH_MSG: begin
          if (symCnt == SYM_LAST) begin
            phase  <= PH_PAR;
            symCnt <= '0;
          end else begin
            symCnt <= symCnt + 1'b1;
            if (inLast) phase <= PH_PAD;
          end
        end
        PH_PAD: begin
          if (symCnt == SYM_LAST) begin
            phase  <= PH_PAR;
            symCnt <= '0;
          end else begin
            symCnt <= symCnt + 1'b1;
          end
        end
        default: begin
          if (parCnt == PAR_LAST) begin
            phase  <= PH_MSG;
            parCnt <= '0;
          end else begin
            parCnt <= parCnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R3: after the last parity word the next word is a message word
  p_block_end_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && outParity && parCnt == PAR_LAST) |=> (!outParity && outWrite));

  // R5: early end of page starts zero padding
  p_pad_start_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inLast && symCnt != SYM_LAST) |=> (outValid && !outWrite));

  // R6: a full block goes straight to parity
  p_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    (fire && outWrite && !outParity && symCnt == SYM_LAST) |=> outParity);

  // R7: input is refused while padding or parity is offered
  p_no_take_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && (outParity || !outWrite)) |-> !inReady);

  // R8: a stalled padding/parity word keeps its kind
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((outParity || !outWrite) && !outReady) |=>
      ($stable(outParity) && $stable(outWrite) && outValid));

endmodule

// File: rtl/rs_page_encoder.sv
module rs_page_encoder
  import rs_enc_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int MSG_LEN = 243,
  parameter int NPAR    = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [LANES*SYM_W-1:0] inData,
  input  logic                   inLast,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [LANES*SYM_W-1:0] outData,
  output logic                   outWrite,
  output logic                   outParity
);

  laneCtl_t ctl;

  rs_enc_ctrl #(.MSG_LEN(MSG_LEN), .NPAR(NPAR)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inLast    (inLast),
    .outReady  (outReady),
    .inReady   (inReady),
    .outValid  (outValid),
    .outWrite  (outWrite),
    .outParity (outParity),
    .ctl       (ctl)
  );

  rs_enc_datapath #(.LANES(LANES), .NPAR(NPAR)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: tb/rs_page_encoder_bench.sv
module rs_page_encoder_bench;

  localparam int LANES   = 2;
  localparam int MSG_LEN = 5;
  localparam int NPAR    = 12;
  localparam int QMAX    = 128;

  // stimulus table: words per page, data seed, mode
  // mode bit0: output stalls, bit1: input gaps, bit2: blocks repeat
  localparam int NVEC = 6;
  localparam int V_WORDS [NVEC] = '{5, 7, 1, 10, 13, 4};
  localparam int V_SEED  [NVEC] = '{3, 11, 200, 17, 99, 85};
  localparam int V_MODE  [NVEC] = '{0, 0, 1, 6, 3, 2};

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, inReady, inLast;
  logic        outValid, outReady, outWrite, outParity;
  logic [15:0] inData, outData;

  int checks = 0;
  int fails  = 0;

  int expT [256];
  int logT [256];
  int gDesc [NPAR+1];
  int msgBuf [MSG_LEN];
  int parBuf [LANES][NPAR];
  logic [17:0] expQ [QMAX];
  logic [15:0] gotQ [QMAX];

  always #4 clk = ~clk;

  rs_page_encoder #(.LANES(LANES), .MSG_LEN(MSG_LEN), .NPAR(NPAR)) u_rs_page_encoder (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outWrite(outWrite), .outParity(outParity)
  );

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return expT[(logT[a] + logT[b]) % 255];
  endfunction

  task automatic buildTables();
    int x = 1;
    int c [NPAR+1];
    for (int i = 0; i < 255; i++) begin
      expT[i] = x;
      logT[x] = i;
      x = x << 1;
      if ((x & 256) != 0) x = x ^ 'h11D;
    end
    for (int j = 0; j <= NPAR; j++) c[j] = 0;
    c[0] = 1;
    for (int k = 0; k < NPAR; k++) begin
      for (int j = NPAR; j > 0; j--) c[j] = c[j-1] ^ gmul(c[j], expT[k]);
      c[0] = gmul(c[0], expT[k]);
    end
    for (int j = 0; j <= NPAR; j++) gDesc[j] = c[NPAR-j];
  endtask

  task automatic encodeLane(int lane);
    int w [MSG_LEN+NPAR];
    for (int i = 0; i < MSG_LEN+NPAR; i++) w[i] = (i < MSG_LEN) ? msgBuf[i] : 0;
    for (int i = 0; i < MSG_LEN; i++) begin
      int coef = w[i];
      for (int j = 1; j <= NPAR; j++) w[i+j] = w[i+j] ^ gmul(coef, gDesc[j]);
    end
    for (int j = 0; j < NPAR; j++) parBuf[lane][j] = w[MSG_LEN+j];
  endtask

  function automatic logic [7:0] pageByte(int seed, int n, int mode);
    int nn = ((mode & 4) != 0) ? (n % (2*MSG_LEN)) : n;
    return 8'((seed*37 + nn*13 + nn*nn) & 255);
  endfunction

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic runPage(int nw, int seed, int mode);
    int expN = 0, expPad = 0, padSeen = 0;
    int wi = 0, oi = 0, cyc = 0;
    int nBlk = (nw + MSG_LEN - 1) / MSG_LEN;
    logic prevHold = 1'b0;
    logic [17:0] prevOut = '0;
    for (int b = 0; b < nBlk; b++) begin
      for (int l = 0; l < LANES; l++) begin
        for (int k = 0; k < MSG_LEN; k++) begin
          int n = b*MSG_LEN + k;
          msgBuf[k] = (n < nw) ? int'(pageByte(seed, 2*n + l, mode)) : 0;
        end
        encodeLane(l);
      end
      for (int k = 0; k < MSG_LEN; k++) begin
        int n = b*MSG_LEN + k;
        if (n < nw) expQ[expN] = {2'b10, pageByte(seed, 2*n+1, mode), pageByte(seed, 2*n, mode)};
        else begin expQ[expN] = 18'h0; expPad++; end
        expN++;
      end
      for (int j = 0; j < NPAR; j++) begin
        expQ[expN] = {2'b11, 8'(parBuf[1][j]), 8'(parBuf[0][j])};
        expN++;
      end
    end
    while (oi < expN) begin
      @(negedge clk);
      outReady = ((mode & 1) != 0) ? ((cyc % 3) != 2) : 1'b1;
      inValid  = (wi < nw) && !(((mode & 2) != 0) && ((cyc % 4) == 1));
      inData   = (wi < nw) ? {pageByte(seed, 2*wi+1, mode), pageByte(seed, 2*wi, mode)} : 16'hDEAD;
      inLast   = (wi == nw - 1);
      #1;
      if (prevHold) begin
        check("R8", int'({outWrite, outParity, outData}), int'(prevOut), "stalled word changed");
        check("R8", int'(outValid), 1, "valid dropped in stall");
      end
      prevHold = outValid && !outReady && (outParity || !outWrite);
      prevOut  = {outWrite, outParity, outData};
      if (outValid && (outParity || !outWrite))
        check("R7", int'(inReady), 0, "ready during pad/parity");
      if (outValid && outReady) begin
        if (expQ[oi][17:16] == 2'b11)
          check("R3,R4", int'({outWrite, outParity, outData}), int'(expQ[oi]), "parity word");
        else if (expQ[oi][17:16] == 2'b00)
          check("R5", int'({outWrite, outParity, outData}), int'(expQ[oi]), "padding word");
        else
          check("R2", int'({outWrite, outParity, outData}), int'(expQ[oi]), "message word");
        if (!outWrite) padSeen++;
        gotQ[oi] = outData;
        oi++;
      end
      if (inValid && inReady) wi++;
      cyc++;
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    check(expPad == 0 ? "R6" : "R5", padSeen, expPad, "padding word count");
    if ((mode & 4) != 0 && nBlk >= 2)
      for (int j = 0; j < NPAR; j++)
        check("R9", int'(gotQ[2*MSG_LEN + NPAR + j]), int'(gotQ[MSG_LEN + j]), "repeat block parity");
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    buildTables();
    rst = 1'b1; inValid = 1'b0; inLast = 1'b0; inData = '0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", int'(outValid), 0, "outValid after reset");
    check("R1", int'(inReady), 1, "inReady after reset");
    check("R1", int'(outParity), 0, "outParity after reset");

    for (int v = 0; v < NVEC; v++) runPage(V_WORDS[v], V_SEED[v], V_MODE[v]);

    // R1: reset mid-page must leave no remainder behind
    @(negedge clk);
    inValid = 1'b1; inData = 16'hA5C3; inLast = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    runPage(V_WORDS[0], V_SEED[0], V_MODE[0]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule